// File: doc/BRIEF.md
# Indirect Address/Data Register Bridge

This block gives a host access to a wide internal register space through a narrow window of only three registers per channel: a pointer register, a data register and a control register. There are two channels. Channel 0 serves the top-level control registers, which are full bus width. Channel 1 serves the controller-core registers, which are 8 bits wide. Each channel drives its own internal request port, made of an address, write data, a write strobe, a read strobe and returned read data.

The host must follow a fixed ordering. It loads the pointer twice with the same value, and only then is a data access armed. A write needs one store to the data register, and that store commits the value to the internal register. A read needs two loads of the data register. The first load returns the previously latched word and launches the internal fetch. The second load returns the fetched word. A completed write, or the second load of a read, disarms the channel.

Bit 15 of each channel's control register decides what happens when a data access is not armed. If the bit is set, the access answers with an error response. If the bit is clear, the access completes silently: a write is dropped and a read returns zero.

Top module: `ireg_bridge`

## Requirements
- R1: After reset, `host_ack`, `host_err`, `int_wr` and `int_rd` are all 0. Every pointer, control and latch register reads back as 0.
- R2: Window offset bit 4 selects the channel (0 selects channel 0, 1 selects channel 1). Offset bits 3:2 select the register: 0 is the pointer, 1 is data, 2 is control. `host_ack` rises in the cycle after each `host_req` and carries the response for that request.
- R3: A pointer store keeps only bits 15:0 of the written word. A pointer load returns those 16 bits zero-extended. The held pointer is presented on that channel's `int_addr` field, at bits 16*ch+15:16*ch.
- R4: A data access is armed only after two consecutive pointer stores of the same value. A store of a different value restarts the count with the new value.
- R5: An armed data store pulses `int_wr[ch]` for exactly one cycle, in the cycle after the request. During that pulse `int_wdata` (bits 32*ch+31:32*ch) carries the stored word. For channel 1 the word is cut to its low 8 bits and zero-extended.
- R6: The first armed data load returns the previously latched word and pulses `int_rd[ch]` in the following cycle. The second data load returns the word fetched by that pulse, even when it follows back to back. Channel 1 zero-extends the fetched byte.
- R7: The arming clears after a committed write and after the second load of a read. A further data access then needs two new pointer stores.
- R8: A data access that is not armed answers with `host_err` = 1 when control bit 15 is set, and with `host_err` = 0 otherwise. In both cases a store produces no `int_wr` pulse and a load returns 0 and produces no `int_rd` pulse.
- R9: The control register stores only bit 15, and a load of it returns only that bit. Control accesses never raise `host_err`.
- R10: The two channels keep fully separate state. Traffic on one channel neither arms nor disarms the other, and at most one internal strobe is active in any cycle.
- R11: An offset whose bits 3:2 equal 3, or whose bits 1:0 are nonzero, returns 0 with no error and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Host access request, one cycle |
| host_we | input | 1 | 1 = store, 0 = load |
| host_addr | input | 5 | Window byte offset |
| host_wdata | input | 32 | Host store data |
| host_ack | output | 1 | Response valid, one cycle after request |
| host_rdata | output | 32 | Host load data |
| host_err | output | 1 | Error response |
| int_addr | output | 32 | Internal register address, 16 bits per channel |
| int_wdata | output | 64 | Internal write data, 32 bits per channel |
| int_wr | output | 2 | Internal write strobe per channel |
| int_rd | output | 2 | Internal read strobe per channel |
| int_rdata | input | 64 | Internal read data, 32 bits per channel |

## Verification
Wrong internal state shows up directly at the host port.

- A stuck or premature arming flag shows as an `int_wr` or `int_rd` pulse where none was expected, or as an error response where the bench expected none. Either appears in the response cycle that follows the offending data access.
- A phase bit that is out of step makes the second load return the stale latch instead of the fetched word.
- A missing bypass of the fetch result breaks back-to-back read pairs on their very next response.
- A wrong latch value shows up on the first load of the next read sequence on that channel.

// File: rtl/ireg_pkg.sv
package ireg_pkg;
   typedef enum logic [1:0] {
      ROLE_PTR  = 2'd0,
      ROLE_DATA = 2'd1,
      ROLE_CTRL = 2'd2,
      ROLE_NONE = 2'd3
   } role_t;

   localparam int NCH    = 2;
   localparam int WIN_AW = 5;
   localparam int ERR_EN_BIT = 15;
endpackage

// File: rtl/ireg_arm.sv
// Double-store arming tracker for one channel's pointer register.
module ireg_arm #(
   parameter int AW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] val,
   input  logic          clr,
   output logic          armed,
   output logic [AW-1:0] ptr
);
   logic seen_one;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         seen_one <= 1'b0;
         armed    <= 1'b0;
         ptr      <= '0;
      end else if (load) begin
         armed    <= seen_one && (val == ptr);
         seen_one <= 1'b1;
         ptr      <= val;
      end else if (clr) begin
         armed    <= 1'b0;
         seen_one <= 1'b0;
      end
   end
endmodule

// File: rtl/ireg_chan.sv
// One indirect access channel: pointer, data sequencing, control bit.
module ireg_chan
   import ireg_pkg::*;
#(
   parameter int BUS_W  = 32,
   parameter int DW     = 32,
   parameter int AW     = 16,
   parameter int EN_BIT = ERR_EN_BIT
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             acc,
   input  logic             we,
   input  role_t            role,
   input  logic [BUS_W-1:0] wdata,
   input  logic [BUS_W-1:0] int_rdata,
   output logic [BUS_W-1:0] rsp_rdata,
   output logic             rsp_err,
   output logic [AW-1:0]    int_addr,
   output logic [BUS_W-1:0] int_wdata,
   output logic             int_wr,
   output logic             int_rd
);
   if (DW > BUS_W || AW > BUS_W || EN_BIT >= BUS_W) begin : g_bad_cfg
      $error("ireg_chan: width parameters out of range");
   end

   logic          armed, phase, err_en;
   logic [DW-1:0] latch, wdata_q;
   logic [BUS_W-1:0] latch_w, fresh_w, fetch_w;
   logic ptr_wr, data_wr, data_rd, good_wr, first_rd, second_rd;
   logic unused_bits;

   assign unused_bits = ^{wdata, int_rdata};

   assign ptr_wr    = acc &&  we && role == ROLE_PTR;
   assign data_wr   = acc &&  we && role == ROLE_DATA;
   assign data_rd   = acc && !we && role == ROLE_DATA;
   assign good_wr   = data_wr && armed;
   assign first_rd  = data_rd && armed && !phase;
   assign second_rd = data_rd && armed &&  phase;

   ireg_arm #(.AW(AW)) u_arm (
      .clk(clk), .rst_n(rst_n), .load(ptr_wr), .val(wdata[AW-1:0]),
      .clr(good_wr || second_rd), .armed(armed), .ptr(int_addr)
   );

   if (DW < BUS_W) begin : g_pad
      assign latch_w   = {{(BUS_W-DW){1'b0}}, latch};
      assign fresh_w   = {{(BUS_W-DW){1'b0}}, int_rdata[DW-1:0]};
      assign int_wdata = {{(BUS_W-DW){1'b0}}, wdata_q};
   end else begin : g_full
      assign latch_w   = latch;
      assign fresh_w   = int_rdata[DW-1:0];
      assign int_wdata = wdata_q;
   end

   // bypass: second load right behind the fetch strobe
   assign fetch_w = int_rd ? fresh_w : latch_w;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase   <= 1'b0;
         err_en  <= 1'b0;
         latch   <= '0;
         wdata_q <= '0;
         int_wr  <= 1'b0;
         int_rd  <= 1'b0;
      end else begin
         int_wr <= good_wr;
         int_rd <= first_rd;
         if (good_wr) wdata_q <= wdata[DW-1:0];
         if (int_rd)  latch   <= int_rdata[DW-1:0];
         if (acc && we && role == ROLE_CTRL) err_en <= wdata[EN_BIT];
         if (ptr_wr || good_wr || second_rd) phase <= 1'b0;
         else if (first_rd)                  phase <= 1'b1;
      end
   end

   always_comb begin
      rsp_rdata = '0;
      rsp_err   = 1'b0;
      case (role)
         ROLE_PTR:  rsp_rdata[AW-1:0] = int_addr;
         ROLE_DATA: begin
            if (!armed)      rsp_err   = err_en;
            else if (!we)    rsp_rdata = phase ? fetch_w : latch_w;
         end
         ROLE_CTRL: rsp_rdata[EN_BIT] = err_en;
         default: ;
      endcase
   end
endmodule

// File: rtl/ireg_bridge.sv
// Two-channel indirect register bridge: window decode and host response.
module ireg_bridge
   import ireg_pkg::*;
#(
   parameter int BUS_W   = 32,
   parameter int TOP_DW  = 32,
   parameter int CORE_DW = 8,
   parameter int IADDR_W = 16
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   host_req,
   input  logic                   host_we,
   input  logic [WIN_AW-1:0]      host_addr,
   input  logic [BUS_W-1:0]       host_wdata,
   output logic                   host_ack,
   output logic [BUS_W-1:0]       host_rdata,
   output logic                   host_err,
   output logic [NCH*IADDR_W-1:0] int_addr,
   output logic [NCH*BUS_W-1:0]   int_wdata,
   output logic [NCH-1:0]         int_wr,
   output logic [NCH-1:0]         int_rd,
   input  logic [NCH*BUS_W-1:0]   int_rdata
);
   if (TOP_DW > BUS_W || CORE_DW > BUS_W || IADDR_W > BUS_W) begin : g_bad_cfg
      $error("ireg_bridge: width parameters out of range");
   end

   localparam int CH_BIT = WIN_AW - 1;

   role_t            role;
   logic             sel;
   logic [BUS_W-1:0] rsp_rd  [NCH];
   logic [NCH-1:0]   rsp_err;

   assign sel  = host_addr[CH_BIT];
   assign role = (host_addr[1:0] != 2'b00) ? ROLE_NONE : role_t'(host_addr[3:2]);

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      localparam int DW = (c == 0) ? TOP_DW : CORE_DW;
      ireg_chan #(.BUS_W(BUS_W), .DW(DW), .AW(IADDR_W)) u_chan (
         .clk(clk), .rst_n(rst_n),
         .acc(host_req && (sel == c[0])), .we(host_we), .role(role),
         .wdata(host_wdata), .int_rdata(int_rdata[c*BUS_W +: BUS_W]),
         .rsp_rdata(rsp_rd[c]), .rsp_err(rsp_err[c]),
         .int_addr(int_addr[c*IADDR_W +: IADDR_W]),
         .int_wdata(int_wdata[c*BUS_W +: BUS_W]),
         .int_wr(int_wr[c]), .int_rd(int_rd[c])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         host_ack   <= 1'b0;
         host_rdata <= '0;
         host_err   <= 1'b0;
      end else begin
         host_ack   <= host_req;
         host_rdata <= host_req ? rsp_rd[sel] : '0;
         host_err   <= host_req && rsp_err[sel];
      end
   end
endmodule

// File: rtl/ireg_bridge_chk.sv
// Protocol checker bound to ireg_bridge.
module ireg_bridge_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       host_req,
   input logic       host_we,
   input logic [4:0] host_addr,
   input logic       host_ack,
   input logic       host_err,
   input logic [1:0] int_wr,
   input logic [1:0] int_rd,
   input logic [31:0] int_addr
);
   // R2: response exactly one cycle after each request
   a_r2_ack_follows: assert property (@(posedge clk) disable iff (!rst_n)
      host_req |=> host_ack);
   a_r2_no_spurious_ack: assert property (@(posedge clk) disable iff (!rst_n)
      !host_req |=> !host_ack);
   // R5: write strobe only from a data store on that channel
   a_r5_wr_cause_0: assert property (@(posedge clk) disable iff (!rst_n)
      int_wr[0] |-> $past(host_req && host_we && host_addr == 5'h04));
   a_r5_wr_cause_1: assert property (@(posedge clk) disable iff (!rst_n)
      int_wr[1] |-> $past(host_req && host_we && host_addr == 5'h14));
   // R5: address steady during the write pulse
   a_r5_addr_steady: assert property (@(posedge clk) disable iff (!rst_n)
      int_wr[0] |-> $stable(int_addr[15:0]));
   // R6: read strobe only from a data load, never twice in a row
   a_r6_rd_cause_0: assert property (@(posedge clk) disable iff (!rst_n)
      int_rd[0] |-> $past(host_req && !host_we && host_addr == 5'h04));
   a_r6_rd_cause_1: assert property (@(posedge clk) disable iff (!rst_n)
      int_rd[1] |-> $past(host_req && !host_we && host_addr == 5'h14));
   a_r6_rd_single: assert property (@(posedge clk) disable iff (!rst_n)
      int_rd[0] |=> !int_rd[0]);
   // R8/R9/R11: errors only answer data-register accesses
   a_r8_err_only_data: assert property (@(posedge clk) disable iff (!rst_n)
      host_err |-> host_ack && $past(host_addr[3:0] == 4'h4));
   // R10: at most one internal strobe per cycle
   a_r10_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({int_wr, int_rd}));
endmodule

bind ireg_bridge ireg_bridge_chk u_chk (
   .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
   .host_addr(host_addr), .host_ack(host_ack), .host_err(host_err),
   .int_wr(int_wr), .int_rd(int_rd), .int_addr(int_addr)
);

// File: tb/sim_ireg_bridge.sv
`timescale 1ns/1ps
module sim_ireg_bridge;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_req = 1'b0, host_we = 1'b0;
   logic [4:0]  host_addr = '0;
   logic [31:0] host_wdata = '0;
   logic        host_ack, host_err;
   logic [31:0] host_rdata;
   logic [31:0] int_addr;
   logic [63:0] int_wdata, int_rdata;
   logic [1:0]  int_wr, int_rd;

   always #2.5 clk = ~clk;

   ireg_bridge u0 (.*);

   // internal register files behind the two channels
   logic [31:0] mem_a [256];
   logic [7:0]  mem_b [256];
   assign int_rdata = {24'h0, mem_b[int_addr[23:16]], mem_a[int_addr[7:0]]};
   always @(posedge clk) begin
      if (int_wr[0]) mem_a[int_addr[7:0]]   <= int_wdata[31:0];
      if (int_wr[1]) mem_b[int_addr[23:16]] <= int_wdata[39:32];
   end

   function automatic logic [31:0] init_val(input int i);
      return (i * 32'h01030507) ^ 32'h5A5AC3C3;
   endfunction

   int n_chk = 0, n_err = 0;
   bit done = 0;
   logic [31:0] exp_a [256];
   logic [7:0]  exp_b [256];
   logic [31:0] latch_x [2];
   bit          en_x [2];

   logic        r_ack, r_err;
   logic [31:0] r_data, r_iaddr16, r_iwd;
   logic [1:0]  r_wr, r_rd;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // one host access; inputs applied after a falling edge, sampled at the next
   task automatic acc(input bit ch, input bit we, input logic [3:0] off, input logic [31:0] d);
      host_req = 1'b1; host_we = we; host_addr = {ch, off}; host_wdata = d;
      @(negedge clk);
      r_ack = host_ack; r_err = host_err; r_data = host_rdata;
      r_wr = int_wr; r_rd = int_rd;
      r_iaddr16 = {16'h0, int_addr[ch*16 +: 16]};
      r_iwd = int_wdata[ch*32 +: 32];
      host_req = 1'b0; host_we = 1'b0; host_addr = '0; host_wdata = '0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic [31:0] mask_ch(input bit ch, input logic [31:0] v);
      return ch ? {24'h0, v[7:0]} : v;
   endfunction

   task automatic arm(input bit ch, input logic [31:0] a);
      acc(ch, 1, 4'h0, a); chk("R2 ack on pointer store", {31'h0, r_ack}, 1);
      chk("R9 no err on pointer store", {31'h0, r_err}, 0);
      acc(ch, 1, 4'h0, a);
   endtask

   task automatic do_write(input bit ch, input logic [31:0] a, input logic [31:0] d);
      arm(ch, a);
      acc(ch, 1, 4'h4, d);
      chk("R5 write strobe", {30'h0, r_wr}, ch ? 2 : 1);
      chk("R5 write address", r_iaddr16, {16'h0, a[15:0]});
      chk("R5 write data", r_iwd, mask_ch(ch, d));
      chk("R5 no err on armed store", {31'h0, r_err}, 0);
      if (ch) exp_b[a[7:0]] = d[7:0]; else exp_a[a[7:0]] = d;
   endtask

   task automatic do_read(input bit ch, input logic [31:0] a);
      arm(ch, a);
      chk("R3 pointer readback", r_iaddr16, {16'h0, a[15:0]});
      acc(ch, 0, 4'h4, 0);
      chk("R6 first load returns old latch", r_data, latch_x[ch]);
      chk("R6 fetch strobe", {30'h0, r_rd}, ch ? 2 : 1);
      latch_x[ch] = ch ? {24'h0, exp_b[a[7:0]]} : exp_a[a[7:0]];
      if ($urandom_range(0, 2) == 0) idle(1);
      acc(ch, 0, 4'h4, 0);
      chk("R6 second load returns fetched word", r_data, latch_x[ch]);
      chk("R6 no strobe on second load", {30'h0, r_rd}, 0);
   endtask

   task automatic do_bad(input bit ch, input bit we);
      acc(ch, we, 4'h4, $urandom);
      chk("R8 err per control bit", {31'h0, r_err}, {31'h0, en_x[ch]});
      chk("R8 no internal strobe", {28'h0, r_wr, r_rd}, 0);
      if (!we) chk("R8 unarmed load reads zero", r_data, 0);
   endtask

   task automatic set_en(input bit ch, input bit v);
      acc(ch, 1, 4'h8, {$urandom} & ~32'h8000 | {16'h0, v, 15'h0});
      chk("R9 no err on control store", {31'h0, r_err}, 0);
      acc(ch, 0, 4'h8, 0);
      chk("R9 control readback bit15 only", r_data, {16'h0, v, 15'h0});
      en_x[ch] = v;
   endtask

   initial begin
      for (int i = 0; i < 256; i++) begin
         mem_a[i] = init_val(i); exp_a[i] = init_val(i);
         mem_b[i] = init_val(i + 77) & 8'hFF; exp_b[i] = mem_b[i];
      end
      latch_x[0] = 0; latch_x[1] = 0; en_x[0] = 0; en_x[1] = 0;
      void'($urandom(32'd1234));
      repeat (4) @(negedge clk);
      chk("R1 ack low in reset", {31'h0, host_ack}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 strobes idle", {28'h0, int_wr, int_rd}, 0);
      acc(0, 0, 4'h8, 0); chk("R1 ctrl0 reset", r_data, 0);
      acc(1, 0, 4'h8, 0); chk("R1 ctrl1 reset", r_data, 0);
      acc(0, 0, 4'h0, 0); chk("R1 pointer reset", r_data, 0);
      chk("R2 ack one cycle after request", {31'h0, r_ack}, 1);
      // R3: upper bits of the pointer word are dropped
      acc(1, 1, 4'h0, 32'hBEEF_0123); acc(1, 0, 4'h0, 0);
      chk("R3 pointer keeps low 16", r_data, 32'h0000_0123);
      // R6: first-ever read returns reset latch (0)
      do_read(0, 32'h0000_0010);
      // R4: mismatched pair is not armed
      set_en(0, 1);
      acc(0, 1, 4'h0, 32'h21); acc(0, 1, 4'h0, 32'h22);
      do_bad(0, 1);
      acc(0, 1, 4'h0, 32'h22);
      acc(0, 1, 4'h4, 32'hCAFE_F00D);
      chk("R4 armed after matching store", {30'h0, r_wr}, 1);
      chk("R4 address is the repeated value", r_iaddr16, 32'h22);
      exp_a[8'h22] = 32'hCAFE_F00D;
      // R7: disarmed after the commit
      do_bad(0, 1); do_bad(0, 0);
      // R10: channel 1 traffic leaves channel 0 armed
      arm(0, 32'h33);
      do_write(1, 32'h44, 32'h1234_56A7);
      do_read(1, 32'h44);
      acc(0, 1, 4'h4, 32'h0BAD_CAFE);
      chk("R10 channel 0 still armed", {30'h0, r_wr}, 1);
      exp_a[8'h33] = 32'h0BAD_CAFE;
      do_bad(1, 0);
      // R11: unused offsets
      acc(0, 0, 4'hC, 0);
      chk("R11 unused offset reads zero", r_data, 0);
      chk("R11 unused offset no err", {31'h0, r_err}, 0);
      acc(1, 1, 4'hC, 32'hFFFF_FFFF); acc(1, 1, 4'h5, 32'hFFFF_FFFF);
      acc(1, 0, 4'h8, 0);
      chk("R11 stray store leaves control", r_data, 0);
      do_read(0, 32'h22);
      do_read(0, 32'h33);
      set_en(0, 0);
      do_bad(0, 0);
      // constrained random mix
      for (int k = 0; k < 300; k++) begin
         automatic bit ch = 1'($urandom_range(0, 1));
         automatic logic [31:0] a = {$urandom} & 32'hFFFF_00FF | {16'h0, 8'h0, 8'($urandom_range(0, 15))};
         case ($urandom_range(0, 9))
            0, 1, 2: do_write(ch, a, $urandom);
            3, 4, 5: do_read(ch, a);
            6:       do_bad(ch, 1'($urandom_range(0, 1)));
            7:       set_en(ch, 1'($urandom_range(0, 1)));
            8:       idle($urandom_range(1, 3));
            default: begin acc(ch, 0, 4'h0, 0); chk("R3 pointer load", r_data & 32'hFFFF_0000, 0); end
         endcase
      end
      done = 1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_err++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end
endmodule